// File: doc/BRIEF.md
# Framed Serial Switch-Control Register

This block is the digital front end of a serially programmed bank of eight on/off switches. A host drives three wires into it: a serial clock, a serial data line and an active-low frame select. All three are brought into the system clock domain through synchroniser chains, and their edges are detected there. The system clock must run at least four times faster than the serial clock, which may run at up to 30 MHz.

While the frame select is low, each falling edge of the serial clock moves one data bit into an 8-bit shift register, most significant bit first. Frames may hold any number of bits, and only the last eight bits received are kept. Each bit that leaves the register is repeated on a chain output on the following rising serial-clock edge. Several blocks can therefore be connected in series, each one seeing the stream delayed by eight bits. When the frame select rises, the register contents become the new switch word, and a one-cycle update strobe marks the change. An active-low reset clears the register, the chain output and the switch word, which turns all switches off.

Top module: `serial_switch_ctrl`

## Requirements
- R1: While the frame select is low, every falling edge of the serial clock shifts the sampled data bit into bit 0 of the shift register. The older bits move one place toward bit 7, so the first bit sent ends in bit 7 of an 8-bit frame.
- R2: While the frame select is high, serial-clock and data activity changes neither the shift register, the chain output nor the switch word.
- R3: The switch word changes only when a frame closes, and then takes the shift register contents. Bit i drives switch i+1, and a 1 turns that switch on.
- R4: Frames shorter or longer than eight bits are accepted. The committed word is the last eight bits shifted in, with older register contents filling the high bits of a short frame.
- R5: The chain output changes only on rising serial-clock edges inside a frame. After the k-th rising edge it shows the bit pushed out of bit 7 by the k-th falling edge, so the stream reappears eight bits late and begins with the previous word.
- R6: Every rising edge of the frame select gives exactly one system-cycle update strobe, including for frames with no clock edges. An empty frame leaves the switch word unchanged.
- R7: While reset is low, the shift register, the chain output, the switch word and the strobe are all zero. They stay zero until a frame is written.
- R8: A serial-clock falling edge seen in the same sampled cycle as the frame-select rising edge is dropped. The frame closes with the register as it was before that edge.
- R9: The strobe and the new word appear after the third system-clock rising edge following the frame-select rise at the pin. The chain output updates after the third system-clock rising edge following a serial-clock rise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset, clears all state |
| ser_clk | input | 1 | Serial clock; data is captured on its falling edge, and it idles high |
| ser_din | input | 1 | Serial data, most significant bit first |
| ser_frame_n | input | 1 | Active-low frame select; its rising edge commits the word |
| ser_dout | output | 1 | Chain output, the stream delayed by eight bits |
| sw_word | output | 8 | Committed switch word; bit i controls switch i+1 |
| sw_update | output | 1 | One-cycle strobe when the switch word is committed |

## Verification
A corrupted shift register is not visible at once. It shows on the chain output during the next frame, within eight serial clocks, and on the switch word at the next frame close, which an empty frame can force at any time. A wrong edge decision shows as a bit shifted in or out of place, and the next frame's chain output or committed word exposes it. Commit errors show on the switch word and strobe three system cycles after the frame select rises, so the bench samples at that exact cycle and at the cycle after it.

// File: rtl/sw_ctrl_pkg.sv
package sw_ctrl_pkg;

  // Positions of the serial pins inside the synchroniser vector
  localparam int unsigned IDX_SCLK  = 0;
  localparam int unsigned IDX_DIN   = 1;
  localparam int unsigned IDX_FRAME = 2;
  localparam int unsigned N_SER     = 3;

  typedef struct packed {
    logic rise;
    logic fall;
  } edge_evt_t;

  // Classify the change between two consecutive samples of a line
  function automatic edge_evt_t classify_edge(input logic prev, input logic cur);
    edge_evt_t e;
    e.rise = ~prev & cur;
    e.fall = prev & ~cur;
    return e;
  endfunction

endpackage

// File: rtl/sw_sync.sv
module sw_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < STAGES; g++) stage_q[g] <= RST_VAL;
    end else begin
      stage_q[0] <= d;
      for (int g = 1; g < STAGES; g++) stage_q[g] <= stage_q[g-1];
    end
  end

  assign q = stage_q[LAST];

endmodule

// File: rtl/sw_edge.sv
module sw_edge #(
  parameter int unsigned WIDTH = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);

  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= cur;
  end

  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    sw_ctrl_pkg::edge_evt_t evt;
    assign evt     = sw_ctrl_pkg::classify_edge(prev_q[g], cur[g]);
    assign rise[g] = evt.rise;
    assign fall[g] = evt.fall;
  end

endmodule

// File: rtl/sw_shifter.sv
module sw_shifter #(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              din,
  input  logic              dout_en,
  output logic [WORD_W-1:0] shreg,
  output logic              dout
);

  localparam int unsigned MSB = WORD_W - 1;

  function automatic logic [WORD_W-1:0] shift_in(input logic [WORD_W-1:0] w, input logic b);
    return {w[MSB-1:0], b};
  endfunction

  logic [WORD_W-1:0] shreg_q;
  logic              spill_q;
  logic              dout_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      spill_q <= 1'b0;
    end else if (shift_en) begin
      shreg_q <= shift_in(shreg_q, din);
      spill_q <= shreg_q[MSB];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dout_q <= 1'b0;
    else if (dout_en) dout_q <= spill_q;
  end

  assign shreg = shreg_q;
  assign dout  = dout_q;

endmodule

// File: rtl/sw_commit.sv
module sw_commit #(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] d,
  output logic [WORD_W-1:0] word,
  output logic              strobe
);

  logic [WORD_W-1:0] word_q;
  logic              strobe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q   <= '0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= load;
      if (load) word_q <= d;
    end
  end

  assign word   = word_q;
  assign strobe = strobe_q;

endmodule

// File: rtl/serial_switch_ctrl.sv
module serial_switch_ctrl #(
  parameter int unsigned WORD_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_din,
  input  logic              ser_frame_n,
  output logic              ser_dout,
  output logic [WORD_W-1:0] sw_word,
  output logic              sw_update
);

  import sw_ctrl_pkg::*;

  // Idle levels: frame select high, data low, serial clock high
  localparam logic [N_SER-1:0] SER_IDLE = N_SER'(3'b101);
  localparam logic [1:0]       EDGE_IDLE = 2'b11;

  logic [N_SER-1:0] ser_raw;
  logic [N_SER-1:0] ser_s;
  logic [1:0]       edge_rise;
  logic [1:0]       edge_fall;

  // Named internal events
  logic              sclk_rise;
  logic              sclk_fall;
  logic              frame_start;
  logic              frame_close;
  logic              frame_open;
  logic              shift_en;
  logic              dout_en;
  logic [WORD_W-1:0] shreg_q;

  assign ser_raw[IDX_SCLK]  = ser_clk;
  assign ser_raw[IDX_DIN]   = ser_din;
  assign ser_raw[IDX_FRAME] = ser_frame_n;

  sw_sync #(
    .WIDTH   (N_SER),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (SER_IDLE)
  ) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (ser_raw),
    .q     (ser_s)
  );

  sw_edge #(
    .WIDTH   (2),
    .RST_VAL (EDGE_IDLE)
  ) edge_i (
    .clk   (clk),
    .rst_n (rst_n),
    .cur   ({ser_s[IDX_FRAME], ser_s[IDX_SCLK]}),
    .rise  (edge_rise),
    .fall  (edge_fall)
  );

  assign sclk_rise   = edge_rise[0];
  assign sclk_fall   = edge_fall[0];
  assign frame_close = edge_rise[1];
  assign frame_start = edge_fall[1];
  assign frame_open  = ~ser_s[IDX_FRAME];

  // A clock edge in the closing cycle sees frame_open low and is dropped
  assign shift_en = sclk_fall & frame_open;
  assign dout_en  = sclk_rise & frame_open;

  sw_shifter #(
    .WORD_W (WORD_W)
  ) shift_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .din      (ser_s[IDX_DIN]),
    .dout_en  (dout_en),
    .shreg    (shreg_q),
    .dout     (ser_dout)
  );

  sw_commit #(
    .WORD_W (WORD_W)
  ) commit_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (frame_close),
    .d      (shreg_q),
    .word   (sw_word),
    .strobe (sw_update)
  );

endmodule

// File: rtl/sw_ctrl_checker.sv
module sw_ctrl_checker #(
  parameter int unsigned WORD_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sclk_rise,
  input logic              shift_en,
  input logic              frame_open,
  input logic              frame_start,
  input logic              frame_close,
  input logic [WORD_W-1:0] shreg,
  input logic [WORD_W-1:0] sw_word,
  input logic              sw_update,
  input logic              ser_dout
);

  assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sw_update |=> !sw_update);

  assert_word_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_update |-> $stable(sw_word));

  assert_commit_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sw_update |-> (sw_word == $past(shreg)));

  assert_closed_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_open) |-> $stable(shreg));

  assert_dout_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ser_dout) |-> $past(sclk_rise));

  assert_close_no_shift_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_close |=> $stable(shreg));

  assert_start_no_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !sw_update);

  assert_shift_in_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |-> !frame_close);

endmodule

bind serial_switch_ctrl sw_ctrl_checker #(.WORD_W(WORD_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .sclk_rise   (sclk_rise),
  .shift_en    (shift_en),
  .frame_open  (frame_open),
  .frame_start (frame_start),
  .frame_close (frame_close),
  .shreg       (shreg_q),
  .sw_word     (sw_word),
  .sw_update   (sw_update),
  .ser_dout    (ser_dout)
);

// File: tb/serial_switch_ctrl_tb_top.sv
`timescale 1ns/1ps
module serial_switch_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ser_clk;
  logic       ser_din;
  logic       ser_frame_n;
  logic       ser_dout;
  logic [7:0] sw_word;
  logic       sw_update;

  always #2.5 clk = ~clk;

  serial_switch_ctrl dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ser_clk     (ser_clk),
    .ser_din     (ser_din),
    .ser_frame_n (ser_frame_n),
    .ser_dout    (ser_dout),
    .sw_word     (sw_word),
    .sw_update   (sw_update)
  );

  int         n_checks = 0;
  int         n_errors = 0;
  logic [7:0] m_sh   = '0;
  logic [7:0] m_word = '0;
  logic       m_spill = 1'b0;

  task automatic chk(input logic ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic open_frame();
    @(negedge clk);
    ser_frame_n = 1'b0;
    wait_cyc(6);
  endtask

  // R1, R5: one bit, falling edge then rising edge, six system cycles each
  task automatic shift_bit(input logic b);
    ser_din = b;
    ser_clk = 1'b0;
    m_spill = m_sh[7];
    m_sh    = {m_sh[6:0], b};
    wait_cyc(6);
    ser_clk = 1'b1;
    wait_cyc(6);
    chk(ser_dout == m_spill, "R5", "chain output", ser_dout, m_spill);
  endtask

  // R9, R6, R3: strobe and word after the third rising edge, strobe gone one edge later
  task automatic expect_commit(input string req);
    @(posedge clk);
    @(posedge clk);
    #1 chk(sw_update == 1'b0, "R9", "strobe too early", sw_update, 0);
    @(posedge clk);
    #1 chk(sw_update == 1'b1, "R6", "strobe", sw_update, 1);
    chk(sw_word == m_word, req, "switch word", sw_word, m_word);
    @(posedge clk);
    #1 chk(sw_update == 1'b0, "R6", "strobe width", sw_update, 0);
    wait_cyc(4);
  endtask

  task automatic close_frame(input string req);
    ser_frame_n = 1'b1;
    m_word = m_sh;
    expect_commit(req);
  endtask

  task automatic send(input logic [15:0] v, input int n, input string req);
    open_frame();
    for (int i = n - 1; i >= 0; i--) shift_bit(v[i]);
    close_frame(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  initial begin
    rst_n = 1'b0;
    ser_clk = 1'b1;
    ser_din = 1'b0;
    ser_frame_n = 1'b1;
    wait_cyc(4);
    // R7: reset state
    chk(sw_word == 8'h00, "R7", "word in reset", sw_word, 0);
    chk(sw_update == 1'b0, "R7", "strobe in reset", sw_update, 0);
    chk(ser_dout == 1'b0, "R7", "chain output in reset", ser_dout, 0);
    rst_n = 1'b1;
    wait_cyc(4);
    chk(sw_word == 8'h00, "R7", "word after reset", sw_word, 0);

    // R1, R3, R5: every 8-bit word; the chain output replays the previous word
    for (int v = 0; v < 256; v++) send(16'(v), 8, "R3");

    // R4: short and long frames
    send(16'h0005, 3, "R4");
    send(16'h0ABC, 12, "R4");
    send(16'h0001, 1, "R4");
    send(16'hF00F, 16, "R4");

    // R6: empty frame keeps the word and still strobes
    send(16'h005A, 8, "R3");
    open_frame();
    close_frame("R6");

    // R2: activity with the frame closed changes nothing
    send(16'h00C3, 8, "R3");
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      ser_clk = ~ser_clk;
      ser_din = ~ser_din;
      wait_cyc(5);
      chk(sw_word == 8'hC3, "R2", "word during idle activity", sw_word, 8'hC3);
      chk(ser_dout == m_spill, "R2", "chain output during idle activity", ser_dout, m_spill);
    end
    @(negedge clk);
    ser_clk = 1'b1;
    wait_cyc(6);
    open_frame();
    close_frame("R2");

    // R8: falling clock edge together with frame close is dropped
    open_frame();
    for (int i = 6; i >= 0; i--) shift_bit(1'(7'h2B >> i));
    ser_din = 1'b1;
    ser_clk = 1'b0;
    ser_frame_n = 1'b1;
    m_word = m_sh;
    expect_commit("R8");
    @(negedge clk);
    ser_clk = 1'b1;
    wait_cyc(6);
    open_frame();
    close_frame("R8");

    // R7: reset in service clears the register and word
    send(16'h00A5, 8, "R3");
    @(negedge clk);
    rst_n = 1'b0;
    wait_cyc(2);
    chk(sw_word == 8'h00, "R7", "word after reset pulse", sw_word, 0);
    chk(ser_dout == 1'b0, "R7", "chain output after reset pulse", ser_dout, 0);
    rst_n = 1'b1;
    m_sh = '0;
    m_spill = 1'b0;
    wait_cyc(4);
    open_frame();
    close_frame("R7");
    send(16'h0081, 8, "R1");

    finish_sim();
  end

endmodule